// File: doc/BRIEF.md
# Two-Client Shared Procedure Call Unit

This unit lets two independent clients share one procedure. All handshakes use two-phase transition signalling. An event is any change of a signal's level, whether rising or falling, and there is never a return-to-zero phase. A client asks for service by toggling its request level. The unit toggles that client's grant level when the client is admitted. It then toggles the single procedure request level and waits for the procedure to toggle its done level back to match. Finally it toggles the done level of the client that made the call, and only that client's. All levels are sampled on the rising clock edge, and the clear is synchronous.

Inside the unit, an arbitration stage feeds a call stage. The arbitration stage lets only one grant be outstanding at a time. The call stage remembers which client it is serving, in the same way a return address is saved, and steers the procedure's completion back to that client. A separate monitor watches for protocol misuse.

Arbitration FSM (`spc_arbiter`):
- States: `ARB_IDLE`, `ARB_HOLD1` (client 1 granted), `ARB_HOLD2` (client 2 granted).
- Transition *admit1*: `ARB_IDLE` to `ARB_HOLD1`. Taken when client 1 is pending and either client 2 is not pending or client 1 holds the priority.
- Transition *admit2*: `ARB_IDLE` to `ARB_HOLD2`. Taken in the remaining cases where client 2 is pending.
- Transitions *release1* and *release2*: from the hold state back to `ARB_IDLE`, once the matching client-done event has been seen.

Call FSM (`spc_call`):
- States: `CALL_IDLE`, `CALL_RUN1`, `CALL_RUN2`.
- Transitions *invoke1* and *invoke2*: from `CALL_IDLE` on a grant event. These toggle the procedure request and record the caller.
- Transitions *return1* and *return2*: from the run state back to `CALL_IDLE`, once the procedure done level equals the procedure request level. These toggle the matching client done.

Error monitor FSM (`spc_errmon`):
- States: `ERR_CLEAN`, `ERR_SET`.
- Transition *violate*: `ERR_CLEAN` to `ERR_SET`.
- `ERR_SET` is left only through clear.

Top module: `spc_unit`

## Requirements
- R1: While `clr` is high and on the first cycle after it falls, `cli_grant`, `cli_done`, `proc_req` and `err` are all 0. After clear, no grant is outstanding and client 1 holds the priority.
- R2: Suppose the unit is idle and client i toggles `cli_req[i]` (bit 0 is client 1, bit 1 is client 2). Then `cli_grant[i]` toggles at the next rising edge, the other grant bit stays unchanged, and `proc_req` toggles exactly one edge after the grant. `proc_req` toggles once per call.
- R3: At most one client is outstanding at any time. A client is outstanding while `cli_grant[i]` differs from `cli_done[i]`.
- R4: A pending request from the other client receives no grant while a call is outstanding. Its grant toggles on the second rising edge after the edge that toggled the finishing client's done.
- R5: When the procedure completes, only the done bit of the client that was granted toggles. The other client's done bit keeps its level.
- R6: If both clients are pending in the same cycle while the unit is idle and client 1 holds the priority, client 1 is granted first.
- R7: Each grant hands the priority to the other client. Under sustained contention, grants therefore alternate between the two clients.
- R8: `err` rises on the edge after a client toggles its request while its own previous request is still unanswered (`cli_req[i]` differed from `cli_done[i]` before the toggle). `err` stays high until clear. A request toggled after its done has returned never sets `err`.
- R9: The client done toggles on the first rising edge at which `proc_done` equals `proc_req`. For a procedure that matches its done L cycles after it sees the request, the client observes its done L+1 cycles after it observes `proc_req` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| cli_req | input | 2 | Client request levels; a toggle is a call (bit 0 client 1) |
| cli_grant | output | 2 | Client grant levels; toggles when a client is admitted |
| cli_done | output | 2 | Client done levels; toggles when that client's call returns |
| proc_req | output | 1 | Procedure request level; toggles to start the procedure |
| proc_done | input | 1 | Procedure done level; made equal to `proc_req` on completion |
| err | output | 1 | Sticky protocol violation flag |

## Verification
The hardest situation to reach is a client that has just been answered and re-requests immediately, while the other client has been waiting the whole time. In that situation the priority must pass to the waiting client, and the quick re-request must not be mistaken for a violation. The stimulus builds this with a procedure model whose latency can be set. Both clients toggle together, and client 1 re-toggles on the very sample at which its done returns. The bench then checks the exact sample at which the waiting client's grant moves and confirms that `err` stays low.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int NCLI = 2;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_HOLD1 = 2'd1,
        ARB_HOLD2 = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        CALL_IDLE = 2'd0,
        CALL_RUN1 = 2'd1,
        CALL_RUN2 = 2'd2
    } call_state_e;

    typedef enum logic {
        ERR_CLEAN = 1'b0,
        ERR_SET   = 1'b1
    } err_state_e;
endpackage

// File: rtl/spc_arbiter.sv
module spc_arbiter
    import spc_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  logic [NCLI-1:0] req_lvl,
    input  logic [NCLI-1:0] ret_lvl,
    output logic [NCLI-1:0] gnt_lvl
);
    arb_state_e      st, st_nxt;
    logic [NCLI-1:0] gnt_nxt;
    logic            prio, prio_nxt;
    logic [NCLI-1:0] pend;
    logic [NCLI-1:0] outst;

    assign pend  = req_lvl ^ ret_lvl;
    assign outst = gnt_lvl ^ ret_lvl;

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            st      <= ARB_IDLE;
            gnt_lvl <= '0;
            prio    <= 1'b0;
        end else begin
            st      <= st_nxt;
            gnt_lvl <= gnt_nxt;
            prio    <= prio_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        st_nxt   = st;
        gnt_nxt  = gnt_lvl;
        prio_nxt = prio;
        unique case (st)
            ARB_IDLE: begin
                if (pend[0] && (!pend[1] || !prio)) begin
                    gnt_nxt[0] = ~gnt_lvl[0];
                    prio_nxt   = 1'b1;
                    st_nxt     = ARB_HOLD1;
                end else if (pend[1]) begin
                    gnt_nxt[1] = ~gnt_lvl[1];
                    prio_nxt   = 1'b0;
                    st_nxt     = ARB_HOLD2;
                end
            end
            ARB_HOLD1: if (!outst[0]) st_nxt = ARB_IDLE;
            ARB_HOLD2: if (!outst[1]) st_nxt = ARB_IDLE;
            default:   st_nxt = ARB_IDLE;
        endcase
    end

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (clr)
        $onehot0(outst));

    assert_tie_client1_R6: assert property (@(posedge clk) disable iff (clr)
        (st == ARB_IDLE && pend == 2'b11 && !prio) |=> (gnt_lvl[0] != $past(gnt_lvl[0])));

    assert_no_grant_busy_R4: assert property (@(posedge clk) disable iff (clr)
        (st != ARB_IDLE) |=> $stable(gnt_lvl));
endmodule

// File: rtl/spc_call.sv
module spc_call
    import spc_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  logic [NCLI-1:0] gnt_lvl,
    input  logic            proc_ack,
    output logic            proc_req,
    output logic [NCLI-1:0] ret_lvl
);
    call_state_e     st, st_nxt;
    logic [NCLI-1:0] gnt_seen, gnt_seen_nxt;
    logic [NCLI-1:0] ret_nxt;
    logic            preq_nxt;
    logic [NCLI-1:0] gnt_evt;
    logic            proc_fin;

    assign gnt_evt  = gnt_lvl ^ gnt_seen;
    assign proc_fin = (proc_ack == proc_req);

    always_ff @(posedge clk) begin
        if (clr) begin
            st       <= CALL_IDLE;
            gnt_seen <= '0;
            ret_lvl  <= '0;
            proc_req <= 1'b0;
        end else begin
            st       <= st_nxt;
            gnt_seen <= gnt_seen_nxt;
            ret_lvl  <= ret_nxt;
            proc_req <= preq_nxt;
        end
    end

    always_comb begin
        st_nxt       = st;
        gnt_seen_nxt = gnt_seen;
        ret_nxt      = ret_lvl;
        preq_nxt     = proc_req;
        unique case (st)
            CALL_IDLE: begin
                if (gnt_evt[0]) begin
                    gnt_seen_nxt[0] = gnt_lvl[0];
                    preq_nxt        = ~proc_req;
                    st_nxt          = CALL_RUN1;
                end else if (gnt_evt[1]) begin
                    gnt_seen_nxt[1] = gnt_lvl[1];
                    preq_nxt        = ~proc_req;
                    st_nxt          = CALL_RUN2;
                end
            end
            CALL_RUN1: if (proc_fin) begin
                ret_nxt[0] = ~ret_lvl[0];
                st_nxt     = CALL_IDLE;
            end
            CALL_RUN2: if (proc_fin) begin
                ret_nxt[1] = ~ret_lvl[1];
                st_nxt     = CALL_IDLE;
            end
            default: st_nxt = CALL_IDLE;
        endcase
    end

    // the arbiter in front must never start a call over a running one
    assert_call_idle_on_grant_R3: assert property (@(posedge clk) disable iff (clr)
        (gnt_evt != '0) |-> (st == CALL_IDLE));

    assert_preq_from_idle_R2: assert property (@(posedge clk) disable iff (clr)
        (proc_req != $past(proc_req)) |-> ($past(st) == CALL_IDLE));

    assert_ret1_matches_R5: assert property (@(posedge clk) disable iff (clr)
        (ret_lvl[0] != $past(ret_lvl[0])) |-> ($past(st) == CALL_RUN1));

    assert_ret2_matches_R5: assert property (@(posedge clk) disable iff (clr)
        (ret_lvl[1] != $past(ret_lvl[1])) |-> ($past(st) == CALL_RUN2));
endmodule

// File: rtl/spc_errmon.sv
module spc_errmon
    import spc_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  logic [NCLI-1:0] req_lvl,
    input  logic [NCLI-1:0] ret_lvl,
    output logic            err
);
    err_state_e      st, st_nxt;
    logic [NCLI-1:0] req_q;
    logic [NCLI-1:0] violate;

    // a new request event while the previous one is unanswered
    assign violate = (req_lvl ^ req_q) & (req_q ^ ret_lvl);

    always_ff @(posedge clk) begin
        if (clr) begin
            st    <= ERR_CLEAN;
            req_q <= '0;
        end else begin
            st    <= st_nxt;
            req_q <= req_lvl;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ERR_CLEAN: if (violate != '0) st_nxt = ERR_SET;
            ERR_SET:   st_nxt = ERR_SET;
            default:   st_nxt = ERR_CLEAN;
        endcase
    end

    assign err = (st == ERR_SET);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (clr)
        err |=> err);
endmodule

// File: rtl/spc_unit.sv
module spc_unit
    import spc_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic [1:0] cli_req,
    output logic [1:0] cli_grant,
    output logic [1:0] cli_done,
    output logic       proc_req,
    input  logic       proc_done,
    output logic       err
);
    logic [NCLI-1:0] gnt_w;
    logic [NCLI-1:0] ret_w;

    spc_arbiter u_arb (
        .clk     (clk),
        .clr     (clr),
        .req_lvl (cli_req),
        .ret_lvl (ret_w),
        .gnt_lvl (gnt_w)
    );

    spc_call u_call (
        .clk      (clk),
        .clr      (clr),
        .gnt_lvl  (gnt_w),
        .proc_ack (proc_done),
        .proc_req (proc_req),
        .ret_lvl  (ret_w)
    );

    spc_errmon u_err (
        .clk     (clk),
        .clr     (clr),
        .req_lvl (cli_req),
        .ret_lvl (ret_w),
        .err     (err)
    );

    assign cli_grant = gnt_w;
    assign cli_done  = ret_w;

    assert_done_after_grant_R5: assert property (@(posedge clk) disable iff (clr)
        $onehot0(cli_grant ^ cli_done));
endmodule

// File: tb/sim_spc_unit.sv
`timescale 1ns/1ps
module sim_spc_unit;
    logic       clk = 1'b0;
    logic       clr;
    logic [1:0] cli_req;
    logic [1:0] cli_grant;
    logic [1:0] cli_done;
    logic       proc_req;
    logic       proc_done;
    logic       err;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    int cnt     = 0;

    always #2 clk = ~clk;

    spc_unit u0 (
        .clk       (clk),
        .clr       (clr),
        .cli_req   (cli_req),
        .cli_grant (cli_grant),
        .cli_done  (cli_done),
        .proc_req  (proc_req),
        .proc_done (proc_done),
        .err       (err)
    );

    // procedure model with settable latency
    always @(negedge clk) begin
        if (clr) begin
            proc_done <= 1'b0;
            cnt = 0;
        end else if (proc_req != proc_done) begin
            if (cnt >= lat) begin
                proc_done <= proc_req;
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ret(input int i);
        for (int k = 0; k < 300; k++) begin
            if (cli_done[i] == cli_req[i]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        clr = 1'b1;
        cli_req = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 grant in clear", cli_grant, 0);
        chk("R1 done in clear", cli_done, 0);
        chk("R1 preq/err in clear", {proc_req, err}, 0);
        clr = 1'b0;
        @(negedge clk);
        chk("R1 outputs after clear", {cli_grant, cli_done, proc_req, err}, 0);
    endtask

    task automatic t_single(input int i, input int l);
        logic [1:0] g0, d0;
        logic       p0;
        int         k;
        lat = l;
        @(negedge clk);
        g0 = cli_grant; d0 = cli_done; p0 = proc_req;
        cli_req[i] = ~cli_req[i];
        @(negedge clk);
        chk("R2 grant toggles", cli_grant ^ g0, 1 << i);
        chk("R2 preq not yet", proc_req, p0);
        @(negedge clk);
        chk("R2 preq toggles", proc_req, !p0);
        k = 0;
        while (cli_done[i] == d0[i] && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk("R9 return latency", k, l + 1);
        chk("R5 only caller done", cli_done ^ d0, 1 << i);
        chk("R8 no err on clean call", err, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_hold();
        logic ok;
        t_reset();
        lat = 15;
        cli_req[0] = 1'b1;
        @(negedge clk);
        cli_req[1] = 1'b1;
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (cli_grant[1] != 1'b0) ok = 1'b0;
            if ((cli_grant ^ cli_done) == 2'b11) ok = 1'b0;
        end
        chk("R4 client2 waits while busy", ok, 1);
        chk("R3 single outstanding", $countones(cli_grant ^ cli_done) <= 1, 1);
        wait_ret(0);
        chk("R4 no grant at return", cli_grant[1], 0);
        @(negedge clk);
        chk("R4 no grant one after", cli_grant[1], 0);
        @(negedge clk);
        chk("R4 grant two after", cli_grant[1], 1);
        wait_ret(1);
        chk("R5 client2 done", cli_done, 2'b11);
    endtask

    task automatic t_tie();
        t_reset();
        lat = 3;
        cli_req = 2'b11;
        @(negedge clk);
        chk("R6 tie grants client1", cli_grant, 2'b01);
        wait_ret(0);
        wait_ret(1);
        chk("R6 both served", cli_done, 2'b11);
        chk("R3 grants settle", cli_grant, 2'b11);
    endtask

    task automatic t_alt();
        t_reset();
        lat = 4;
        cli_req = 2'b11;
        @(negedge clk);
        wait_ret(0);
        cli_req[0] = 1'b0;
        @(negedge clk);
        chk("R7 no grant yet", cli_grant, 2'b01);
        @(negedge clk);
        chk("R7 client2 after client1", cli_grant, 2'b11);
        chk("R8 quick re-request no err", err, 0);
        wait_ret(1);
        repeat (2) @(negedge clk);
        chk("R7 client1 after client2", cli_grant, 2'b10);
        wait_ret(0);
        chk("R7 all answered", cli_done, cli_req);
        chk("R8 still clean", err, 0);
    endtask

    task automatic t_err();
        t_reset();
        lat = 10;
        cli_req[1] = 1'b1;
        @(negedge clk);
        chk("R8 err low while pending", err, 0);
        cli_req[1] = 1'b0;
        @(negedge clk);
        chk("R8 err on nested request", err, 1);
        repeat (5) @(negedge clk);
        chk("R8 err sticky", err, 1);
        t_reset();
        chk("R1 clear drops err", err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clr = 1'b1;
        cli_req = 2'b00;
        t_reset();
        t_single(0, 0);
        t_single(1, 0);
        t_single(0, 7);
        t_single(1, 3);
        t_hold();
        t_tie();
        t_alt();
        t_err();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule